// File: doc/BRIEF.md
# Table Write Byte-Lane Steering Unit

This block turns a single-byte table write into data and strobes for an external program-memory bus that is either 16 bits or 8 bits wide. Each write request carries a byte pointer and one data byte. The unit decides which half of the bus carries the byte, which write strobe fires, and which byte-enable lines are asserted. It decides this from the bus width and from a stored 2-bit write-mode field.

Three lane policies serve three kinds of 16-bit memory. Byte-write mode suits a pair of byte-wide parts. Byte-select mode suits word-wide parts that have upper and lower byte enables. Word-write mode suits word-wide parts that accept only whole words. In word-write mode, an even-address write is held back in an internal holding register. The full word goes out only when the odd-address write arrives.

The bus-cycle quarters are abstracted to one write-phase cycle. That cycle is the clock cycle after the request is sampled.

Top module: `tw_lane_steer`

## Requirements
- R1: After a synchronous reset, all strobes (`wr_hi_n`, `wr_lo_n`, `ub_n`, `lb_n`) are high, `bus_oe` is 0 and `bus_dout` is 0. The write-mode field resets to byte-write (code 00), and the holding register resets to 00h.
- R2: A write request sampled at a rising edge produces its write phase in exactly the next cycle, and only in that cycle. In every other cycle all strobes are high and `bus_oe` is 0.
- R3: Byte-write mode (code 00) on the 16-bit bus:
  - the byte is driven on both halves of `bus_dout`;
  - pointer bit 0 = 0 pulls only `wr_lo_n` low, and bit 0 = 1 pulls only `wr_hi_n` low;
  - `ub_n` and `lb_n` stay high.
- R4: Byte-select mode (code 01) on the 16-bit bus:
  - the byte is driven on both halves of `bus_dout`;
  - `wr_hi_n` is pulled low on every write, and `wr_lo_n` stays high;
  - an odd pointer pulls `ub_n` low, and an even pointer pulls `lb_n` low.
- R5: Word-write mode (codes 10 and 11) on the 16-bit bus, even pointer: the byte is stored in the holding register, `bus_oe` stays 0, and no strobe fires.
- R6: Word-write mode on the 16-bit bus, odd pointer:
  - `bus_dout` is {new byte, held byte};
  - `wr_hi_n` goes low, `wr_lo_n` stays high;
  - `ub_n` and `lb_n` both go low.
- R7: An odd word-write with no preceding even write uses whatever the holding register contains (00h after reset).
- R8: `ba0` equals pointer bit 0 from the previous cycle, in every mode and also in idle cycles.
- R9: On the 8-bit bus (`bus_wide` = 0) the mode field is ignored:
  - the byte appears on `bus_dout[7:0]` with the upper byte 0;
  - only `wr_lo_n` goes low;
  - the holding register is left unchanged.
- R10: The mode field is loaded when `cfg_we` is 1 at a rising edge. Code 11 behaves exactly like code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the write-mode field |
| cfg_mode | input | 2 | New write-mode code (00 byte-write, 01 byte-select, 1x word-write) |
| bus_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| wr_req | input | 1 | Table write request, one cycle per byte |
| byte_ptr | input | PTR_W | Byte pointer of the write |
| wr_data | input | DATA_W | Table latch byte |
| bus_dout | output | 2*DATA_W | External bus write data |
| bus_oe | output | 1 | Bus driven during the write phase |
| wr_hi_n | output | 1 | High write strobe, active low |
| wr_lo_n | output | 1 | Low write strobe, active low |
| ub_n | output | 1 | Upper byte enable, active low |
| lb_n | output | 1 | Lower byte enable, active low |
| ba0 | output | 1 | Byte address bit 0 |

## Verification
Every strobe, enable and data result is due exactly one cycle after the edge that samples `wr_req`. `ba0` is due one cycle after the pointer it mirrors.

The driver tags each expected write-phase item with the cycle count in which it is due. The monitor samples on the falling edge. In that cycle it compares the item against the bus if the item is due, and otherwise requires the idle pattern. Any item whose due cycle has passed is reported as a failure.

The sequences cover:
- the holding register across odd-first writes, writes on the 8-bit bus, and reset;
- back-to-back writes, so that one-cycle strobe widths are checked directly.

// File: rtl/tw_steer_pkg.sv
package tw_steer_pkg;

  typedef enum logic [1:0] {
    WM_BYTE  = 2'b00,
    WM_BSEL  = 2'b01,
    WM_WORD  = 2'b10,
    WM_WORD2 = 2'b11
  } wmode_e;

  typedef struct packed {
    logic oe;
    logic wrh_n;
    logic wrl_n;
    logic ub_n;
    logic lb_n;
  } lane_ctl_t;

  localparam lane_ctl_t LANE_IDLE = '{oe: 1'b0, wrh_n: 1'b1, wrl_n: 1'b1,
                                      ub_n: 1'b1, lb_n: 1'b1};

endpackage

// File: rtl/tw_mode_reg.sv
module tw_mode_reg
  import tw_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] code,
  output wmode_e     mode
);

  always_ff @(posedge clk) begin
    if (rst)       mode <= WM_BYTE;
    else if (load) mode <= wmode_e'(code);
  end

endmodule

// File: rtl/tw_hold_latch.sv
module tw_hold_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (capture) q <= din;
  end

endmodule

// File: rtl/tw_lane_decode.sv
module tw_lane_decode
  import tw_steer_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BUS_W = 2 * DATA_W
) (
  input  logic              req,
  input  logic              wide,
  input  wmode_e            mode,
  input  logic              odd,
  input  logic [DATA_W-1:0] din,
  input  logic [DATA_W-1:0] held,
  output logic [BUS_W-1:0]  data_nx,
  output lane_ctl_t         ctl_nx,
  output logic              hold_cap
);

  always_comb begin
    data_nx  = '0;
    ctl_nx   = LANE_IDLE;
    hold_cap = 1'b0;
    if (req) begin
      if (!wide) begin
        data_nx      = {{DATA_W{1'b0}}, din};
        ctl_nx.oe    = 1'b1;
        ctl_nx.wrl_n = 1'b0;
      end else begin
        unique case (mode)
          WM_BYTE: begin
            data_nx   = {din, din};
            ctl_nx.oe = 1'b1;
            if (odd) ctl_nx.wrh_n = 1'b0;
            else     ctl_nx.wrl_n = 1'b0;
          end
          WM_BSEL: begin
            data_nx      = {din, din};
            ctl_nx.oe    = 1'b1;
            ctl_nx.wrh_n = 1'b0;
            if (odd) ctl_nx.ub_n = 1'b0;
            else     ctl_nx.lb_n = 1'b0;
          end
          default: begin
            if (!odd) begin
              hold_cap = 1'b1;
            end else begin
              data_nx      = {din, held};
              ctl_nx.oe    = 1'b1;
              ctl_nx.wrh_n = 1'b0;
              ctl_nx.ub_n  = 1'b0;
              ctl_nx.lb_n  = 1'b0;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/tw_lane_steer.sv
module tw_lane_steer
  import tw_steer_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PTR_W  = 21,
  localparam int BUS_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_mode,
  input  logic              bus_wide,
  input  logic              wr_req,
  input  logic [PTR_W-1:0]  byte_ptr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [BUS_W-1:0]  bus_dout,
  output logic              bus_oe,
  output logic              wr_hi_n,
  output logic              wr_lo_n,
  output logic              ub_n,
  output logic              lb_n,
  output logic              ba0
);

  wmode_e            mode;
  logic [DATA_W-1:0] held;
  logic [BUS_W-1:0]  data_nx;
  lane_ctl_t         ctl_nx;
  lane_ctl_t         ctl_q;
  logic              hold_cap;

  tw_mode_reg u_mode (
    .clk  (clk),
    .rst  (rst),
    .load (cfg_we),
    .code (cfg_mode),
    .mode (mode)
  );

  tw_hold_latch #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .capture (hold_cap),
    .din     (wr_data),
    .q       (held)
  );

  tw_lane_decode #(.DATA_W(DATA_W)) u_dec (
    .req      (wr_req),
    .wide     (bus_wide),
    .mode     (mode),
    .odd      (byte_ptr[0]),
    .din      (wr_data),
    .held     (held),
    .data_nx  (data_nx),
    .ctl_nx   (ctl_nx),
    .hold_cap (hold_cap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dout <= '0;
      ctl_q    <= LANE_IDLE;
      ba0      <= 1'b0;
    end else begin
      bus_dout <= data_nx;
      ctl_q    <= ctl_nx;
      ba0      <= byte_ptr[0];
    end
  end

  assign bus_oe  = ctl_q.oe;
  assign wr_hi_n = ctl_q.wrh_n;
  assign wr_lo_n = ctl_q.wrl_n;
  assign ub_n    = ctl_q.ub_n;
  assign lb_n    = ctl_q.lb_n;

endmodule

// File: rtl/tw_lane_steer_chk.sv
module tw_lane_steer_chk #(
  parameter int PTR_W = 21
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_wide,
  input logic             wr_req,
  input logic [PTR_W-1:0] byte_ptr,
  input logic             bus_oe,
  input logic             wr_hi_n,
  input logic             wr_lo_n,
  input logic             ub_n,
  input logic             lb_n,
  input logic             ba0
);

  // R2
  strobe_origin_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_hi_n || !wr_lo_n || !ub_n || !lb_n || bus_oe) |-> $past(wr_req));

  // R2
  idle_after_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_req) |-> (wr_hi_n && wr_lo_n && ub_n && lb_n && !bus_oe));

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !(!wr_hi_n && !wr_lo_n));

  // R6
  both_lanes_need_wrh_chk: assert property (@(posedge clk) disable iff (rst)
    (!ub_n && !lb_n) |-> !wr_hi_n);

  // R8
  ba0_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (ba0 == $past(byte_ptr[0])));

  // R9
  narrow_bus_chk: assert property (@(posedge clk) disable iff (rst)
    $past(wr_req && !bus_wide) |-> (!wr_lo_n && wr_hi_n && ub_n && lb_n && bus_oe));

endmodule

bind tw_lane_steer tw_lane_steer_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_wide (bus_wide),
  .wr_req   (wr_req),
  .byte_ptr (byte_ptr),
  .bus_oe   (bus_oe),
  .wr_hi_n  (wr_hi_n),
  .wr_lo_n  (wr_lo_n),
  .ub_n     (ub_n),
  .lb_n     (lb_n),
  .ba0      (ba0)
);

// File: tb/tw_lane_steer_bench.sv
module tw_lane_steer_bench;

  localparam int DW = 8;
  localparam int PW = 21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_mode = 2'b00;
  logic          bus_wide = 1'b1;
  logic          wr_req = 1'b0;
  logic [PW-1:0] byte_ptr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [15:0]   bus_dout;
  logic          bus_oe, wr_hi_n, wr_lo_n, ub_n, lb_n, ba0;

  always #4 clk = ~clk;

  tw_lane_steer #(.DATA_W(DW), .PTR_W(PW)) u_tw_lane_steer (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .bus_wide(bus_wide), .wr_req(wr_req), .byte_ptr(byte_ptr),
    .wr_data(wr_data), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .wr_hi_n(wr_hi_n), .wr_lo_n(wr_lo_n), .ub_n(ub_n), .lb_n(lb_n), .ba0(ba0)
  );

  typedef struct {
    logic [20:0] vec;
    int          due;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [1:0]  mode_m = 2'b00;
  logic [7:0]  hold_m = 8'h00;
  logic        prev_lsb = 1'b0;
  logic        done = 1'b0;
  localparam logic [20:0] IDLE_V = {16'h0000, 1'b0, 4'b1111};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_lsb <= rst ? 1'b0 : byte_ptr[0];
  end

  task automatic check(input logic [20:0] got, input logic [20:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got data=%h oe/wh/wl/ub/lb=%b exp data=%h oe/wh/wl/ub/lb=%b",
               tag, got[20:5], got[4:0], exp[20:5], exp[4:0]);
    end
  endtask

  // monitor: compares each cycle at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [20:0] got;
      got = {bus_dout, bus_oe, wr_hi_n, wr_lo_n, ub_n, lb_n};
      if (sb.size() > 0 && sb[0].due < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s: item due in cycle %0d missed (now %0d)", sb[0].tag, sb[0].due, cyc);
        void'(sb.pop_front());
      end
      if (sb.size() > 0 && sb[0].due == cyc) begin
        check(got, sb[0].vec, sb[0].tag);
        void'(sb.pop_front());
      end else begin
        check(got, IDLE_V, "R2 idle");
      end
      n_chk++;
      if (ba0 !== prev_lsb) begin
        n_fail++;
        $display("FAIL R8 ba0: got %b exp %b", ba0, prev_lsb);
      end
    end
  end

  function automatic logic [20:0] model(input logic wide, input logic [1:0] m,
                                        input logic odd, input logic [7:0] d);
    if (!wide) return {8'h00, d, 1'b1, 4'b1011};
    case (m)
      2'b00:   return {d, d, 1'b1, odd ? 4'b0111 : 4'b1011};
      2'b01:   return {d, d, 1'b1, odd ? 4'b0101 : 4'b0110};
      default: return odd ? {d, hold_m, 1'b1, 4'b0100} : IDLE_V;
    endcase
  endfunction

  task automatic do_wr(input logic [PW-1:0] p, input logic [7:0] d, input string tag);
    exp_t e;
    wr_req = 1'b1; byte_ptr = p; wr_data = d;
    e.vec = model(bus_wide, mode_m, p[0], d);
    e.due = cyc + 1;
    e.tag = tag;
    sb.push_back(e);
    if (bus_wide && mode_m[1] && !p[0]) hold_m = d;
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    cfg_we = 1'b1; cfg_mode = m;
    @(negedge clk);
    cfg_we = 1'b0;
    mode_m = m;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: expired, exp completion");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check({bus_dout, bus_oe, wr_hi_n, wr_lo_n, ub_n, lb_n}, IDLE_V, "R1 reset outputs");
    idle(1);
    // R1/R3 default mode is byte-write
    do_wr(21'h000100, 8'hA5, "R1 R3 even byte-write");
    do_wr(21'h000101, 8'h5A, "R3 odd byte-write");
    idle(2);
    set_mode(2'b01);
    idle(1);
    do_wr(21'h000200, 8'h12, "R4 even byte-select");
    do_wr(21'h000203, 8'h34, "R4 odd byte-select");
    idle(2);
    set_mode(2'b10);
    idle(1);
    do_wr(21'h000301, 8'hC7, "R7 odd word first, hold 00");
    do_wr(21'h000300, 8'h3C, "R5 even word held");
    idle(1);
    do_wr(21'h000301, 8'h7E, "R6 odd word pair");
    idle(1);
    bus_wide = 1'b0;
    do_wr(21'h000400, 8'h11, "R9 8-bit even, mode ignored");
    do_wr(21'h000401, 8'h99, "R9 8-bit odd");
    bus_wide = 1'b1;
    do_wr(21'h000303, 8'h22, "R9 hold untouched by 8-bit");
    idle(1);
    set_mode(2'b11);
    do_wr(21'h000500, 8'h44, "R10 code 11 even");
    do_wr(21'h000501, 8'h55, "R10 code 11 odd");
    idle(1);
    set_mode(2'b00);
    for (int i = 0; i < 6; i++)
      do_wr(21'h000600 + i, 8'h80 + 8'(i), "R2 back-to-back byte-write");
    idle(1);
    set_mode(2'b01);
    bus_wide = 1'b0;
    do_wr(21'h000701, 8'hE1, "R9 8-bit in byte-select mode");
    bus_wide = 1'b1;
    set_mode(2'b10);
    do_wr(21'h000800, 8'hBB, "R5 load hold before reset");
    idle(2);
    rst = 1'b1; hold_m = 8'h00; mode_m = 2'b00;
    idle(2);
    rst = 1'b0;
    idle(1);
    do_wr(21'h000901, 8'h66, "R1 mode back to byte-write after reset");
    set_mode(2'b10);
    do_wr(21'h000901, 8'h77, "R7 hold cleared by reset");
    idle(3);
    if (sb.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R2: %0d items never seen, exp 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule